// File: doc/BRIEF.md
# Relative-Addressed Register Stack File

This block holds eight data words in a ring and addresses them relative to a moving top-of-stack pointer. ST0 is always the current top, and ST1 to ST7 follow it around the ring. Each physical slot has an occupancy tag. The block takes one command per clock. The commands push a word, push a constant, read the top (with or without a pop), exchange the top with another entry, free an entry, pop once or twice, or apply a two-operand operation.

The arithmetic itself is done outside the block. For a two-operand command, the block presents two operands on a combinational port and writes back the result that arrives on the same cycle. The result goes to ST0 or to a chosen STn, and the top can be popped after the write. The data words are opaque, and the width is a parameter.

An occupied slot that is pushed onto sets a sticky overflow flag. An empty entry that is read or popped sets a sticky underflow flag and supplies zero.

Top module: `rsf_stack_file`

## Requirements
- R1: Reset leaves all eight slots empty, sets the top pointer to physical slot 0, clears both sticky flags and holds rd_valid low.
- R2: Three commands push onto the stack: code 1 pushes cmd_data, code 2 pushes zero and code 3 pushes ONE_VALUE. Each moves the top back by one, modulo 8, and writes the word into the new top slot. The entry that was ST0 becomes ST1.
- R3: Code 4 (read) drives rd_valid high in the next cycle with the ST0 word on rd_data and leaves the stack as it was. Code 5 does the same and then pops the top.
- R4: Code 6 exchanges the words and tags of ST0 and ST(cmd_idx).
- R5: Code 7 marks ST(cmd_idx) empty and leaves the top pointer unchanged. A later read of that entry yields zero.
- R6: Code 10 presents op_a = ST0 and op_b = source, where the source is ST(cmd_idx), or cmd_data when cmd_ext is 1. It writes op_result to ST0 when cmd_to_rel is 0, or to ST(cmd_idx) when cmd_to_rel is 1.
- R7: On code 10 with cmd_rev set to 1, the two operands are swapped: op_a is the source and op_b is ST0.
- R8: On code 10 with cmd_pop set to 1, the block writes the result first and then pops the top, so the old ST1 becomes ST0.
- R9: Code 9 raises op_go, presents op_a = ST0 and op_b = ST1, ignores op_result and pops twice. op_go is high only for codes 9 and 10.
- R10: A push whose target slot is already occupied sets ovf_flag, which stays set until reset.
- R11: A read or pop of an empty entry, or an operand taken from an empty entry, sets unf_flag, which stays set until reset. The empty entry supplies zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_code | input | 4 | Command code |
| cmd_idx | input | 3 | Relative entry index n |
| cmd_to_rel | input | 1 | Operation result goes to ST(n) rather than ST0 |
| cmd_pop | input | 1 | Pop after the operation |
| cmd_rev | input | 1 | Swap the operand order |
| cmd_ext | input | 1 | Source operand taken from cmd_data |
| cmd_data | input | W | Pushed word or external operand |
| op_go | output | 1 | Operands on the operation port are live |
| op_a | output | W | First operand |
| op_b | output | W | Second operand |
| op_result | input | W | Combinational result from the operation unit |
| rd_valid | output | 1 | Read data strobe |
| rd_data | output | W | Word read from ST0 |
| ovf_flag | output | 1 | Sticky overflow |
| unf_flag | output | 1 | Sticky underflow |

## Verification
The assertions assume a few things about the inputs. cmd_code carries only the eleven defined codes while cmd_valid is high. op_result settles within the cycle from op_a and op_b. Reset is held for at least one edge before the first command. The bench keeps within these limits. It drives only listed codes on falling edges, and it builds op_result as op_a minus op_b with a continuous assignment. Because subtraction depends on operand order, any mix-up in operand order or destination shows up as a wrong word in a later read.

// File: rtl/rsf_pkg.sv
package rsf_pkg;

  typedef enum logic [3:0] {
    RC_NOP      = 4'd0,
    RC_PUSH     = 4'd1,
    RC_PUSH0    = 4'd2,
    RC_PUSH1    = 4'd3,
    RC_READ     = 4'd4,
    RC_READPOP  = 4'd5,
    RC_XCHG     = 4'd6,
    RC_FREE     = 4'd7,
    RC_POP      = 4'd8,
    RC_POP2     = 4'd9,
    RC_OP       = 4'd10
  } rsf_cmd_e;

  // Ring position of ST(rel) given the physical top; depth is a power of two.
  function automatic int unsigned ring_slot(int unsigned top, int unsigned rel,
                                            int unsigned depth);
    return (top + rel) % depth;
  endfunction

endpackage

// File: rtl/rsf_bank.sv
module rsf_bank #(
  parameter int W     = 32,
  parameter int DEPTH = 8,
  parameter int PW    = $clog2(DEPTH)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wa_en,
  input  logic [PW-1:0]             wa_slot,
  input  logic [W-1:0]              wa_val,
  input  logic                      wa_full,
  input  logic                      wb_en,
  input  logic [PW-1:0]             wb_slot,
  input  logic [W-1:0]              wb_val,
  input  logic                      wb_full,
  input  logic                      ca_en,
  input  logic [PW-1:0]             ca_slot,
  input  logic                      cb_en,
  input  logic [PW-1:0]             cb_slot,
  output logic [DEPTH-1:0][W-1:0]   masked,
  output logic [DEPTH-1:0]          full
);

  logic [DEPTH-1:0][W-1:0] vals;

  // Tags: writes first, clears last, so a pop after a write leaves the slot empty.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full <= '0;
    end else begin
      if (wa_en) full[wa_slot] <= wa_full;
      if (wb_en) full[wb_slot] <= wb_full;
      if (ca_en) full[ca_slot] <= 1'b0;
      if (cb_en) full[cb_slot] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (wa_en) vals[wa_slot] <= wa_val;
    if (wb_en) vals[wb_slot] <= wb_val;
  end

  // An empty slot always reads as zero.
  for (genvar g = 0; g < DEPTH; g++) begin : g_mask
    assign masked[g] = full[g] ? vals[g] : '0;
  end

endmodule

// File: rtl/rsf_oproute.sv
module rsf_oproute #(
  parameter int W = 32
) (
  input  logic [W-1:0] v_top,
  input  logic [W-1:0] v_rel,
  input  logic [W-1:0] v_next,
  input  logic [W-1:0] ext_data,
  input  logic         use_ext,
  input  logic         rev,
  input  logic         dbl_pop,
  output logic [W-1:0] op_a,
  output logic [W-1:0] op_b
);

  // Returns {a, b}; a reversed order puts the source first.
  function automatic logic [2*W-1:0] order_pair(logic [W-1:0] top, logic [W-1:0] src,
                                                logic swap);
    return swap ? {src, top} : {top, src};
  endfunction

  logic [W-1:0] src;

  always_comb begin
    if (dbl_pop)      src = v_next;
    else if (use_ext) src = ext_data;
    else              src = v_rel;
    {op_a, op_b} = order_pair(v_top, src, rev & ~dbl_pop);
  end

endmodule

// File: rtl/rsf_stack_file.sv
module rsf_stack_file
  import rsf_pkg::*;
#(
  parameter int             W         = 32,
  parameter int             DEPTH     = 8,
  parameter logic [W-1:0]   ONE_VALUE = W'(32'h3F80_0000),
  localparam int            PW        = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  input  logic [3:0]    cmd_code,
  input  logic [PW-1:0] cmd_idx,
  input  logic          cmd_to_rel,
  input  logic          cmd_pop,
  input  logic          cmd_rev,
  input  logic          cmd_ext,
  input  logic [W-1:0]  cmd_data,
  output logic          op_go,
  output logic [W-1:0]  op_a,
  output logic [W-1:0]  op_b,
  input  logic [W-1:0]  op_result,
  output logic          rd_valid,
  output logic [W-1:0]  rd_data,
  output logic          ovf_flag,
  output logic          unf_flag
);

  rsf_cmd_e cmd;
  assign cmd = rsf_cmd_e'(cmd_code);

  logic [PW-1:0] top_q, s0, s1, sn, sp;
  assign s0 = top_q;
  assign s1 = PW'(ring_slot(int'(top_q), 1, DEPTH));
  assign sn = PW'(ring_slot(int'(top_q), int'(cmd_idx), DEPTH));
  assign sp = PW'(ring_slot(int'(top_q), DEPTH - 1, DEPTH));

  logic [DEPTH-1:0][W-1:0] masked;
  logic [DEPTH-1:0]        full;
  logic [W-1:0]            v0, v1, vn;
  assign v0 = masked[s0];
  assign v1 = masked[s1];
  assign vn = masked[sn];

  // Named events, also watched by the checker.
  logic       push_evt, rd_fire, ovf_evt, unf_evt;
  logic [1:0] pop_cnt;
  logic       wa_en, wb_en, wa_full, wb_full;
  logic [PW-1:0] wa_slot, wb_slot;
  logic [W-1:0]  wa_val, wb_val;
  logic       cb_en;
  logic       free_en;

  always_comb begin
    push_evt = 1'b0; rd_fire = 1'b0; ovf_evt = 1'b0; unf_evt = 1'b0;
    pop_cnt  = 2'd0; op_go = 1'b0; free_en = 1'b0;
    wa_en = 1'b0; wa_slot = s0; wa_val = '0; wa_full = 1'b1;
    wb_en = 1'b0; wb_slot = sn; wb_val = '0; wb_full = 1'b1;
    cb_en = 1'b0;
    if (cmd_valid) begin
      unique case (cmd)
        RC_PUSH, RC_PUSH0, RC_PUSH1: begin
          push_evt = 1'b1;
          ovf_evt  = full[sp];
          wa_en    = 1'b1;
          wa_slot  = sp;
          wa_val   = (cmd == RC_PUSH)  ? cmd_data :
                     (cmd == RC_PUSH1) ? ONE_VALUE : '0;
        end
        RC_READ: begin
          rd_fire = 1'b1;
          unf_evt = ~full[s0];
        end
        RC_READPOP: begin
          rd_fire = 1'b1;
          unf_evt = ~full[s0];
          pop_cnt = 2'd1;
        end
        RC_XCHG: begin
          wa_en = 1'b1; wa_slot = s0; wa_val = vn; wa_full = full[sn];
          wb_en = 1'b1; wb_slot = sn; wb_val = v0; wb_full = full[s0];
        end
        RC_FREE: free_en = 1'b1;
        RC_POP: begin
          unf_evt = ~full[s0];
          pop_cnt = 2'd1;
        end
        RC_POP2: begin
          op_go   = 1'b1;
          unf_evt = ~full[s0] | ~full[s1];
          pop_cnt = 2'd2;
          cb_en   = 1'b1;
        end
        RC_OP: begin
          op_go   = 1'b1;
          unf_evt = ~full[s0] | (~cmd_ext & ~full[sn]);
          wa_en   = 1'b1;
          wa_slot = cmd_to_rel ? sn : s0;
          wa_val  = op_result;
          pop_cnt = cmd_pop ? 2'd1 : 2'd0;
        end
        default: ;
      endcase
    end
  end

  // Port A of the clears pops ST0, or frees ST(n).
  logic          ca_en;
  logic [PW-1:0] ca_slot;
  assign ca_en   = (pop_cnt != 2'd0) | free_en;
  assign ca_slot = free_en ? sn : s0;

  rsf_bank #(.W(W), .DEPTH(DEPTH), .PW(PW)) u_bank (
    .clk(clk), .rst_n(rst_n),
    .wa_en(wa_en), .wa_slot(wa_slot), .wa_val(wa_val), .wa_full(wa_full),
    .wb_en(wb_en), .wb_slot(wb_slot), .wb_val(wb_val), .wb_full(wb_full),
    .ca_en(ca_en), .ca_slot(ca_slot),
    .cb_en(cb_en), .cb_slot(s1),
    .masked(masked), .full(full)
  );

  rsf_oproute #(.W(W)) u_route (
    .v_top(v0), .v_rel(vn), .v_next(v1), .ext_data(cmd_data),
    .use_ext(cmd_ext), .rev(cmd_rev), .dbl_pop(cmd == RC_POP2),
    .op_a(op_a), .op_b(op_b)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      top_q    <= '0;
      ovf_flag <= 1'b0;
      unf_flag <= 1'b0;
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      top_q    <= push_evt ? sp : top_q + PW'(pop_cnt);
      ovf_flag <= ovf_flag | ovf_evt;
      unf_flag <= unf_flag | unf_evt;
      rd_valid <= rd_fire;
      if (rd_fire) rd_data <= v0;
    end
  end

endmodule

// File: rtl/rsf_stack_chk.sv
module rsf_stack_chk #(
  parameter int PW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cmd_valid,
  input logic [3:0]    cmd_code,
  input logic          op_go,
  input logic          rd_valid,
  input logic          ovf_flag,
  input logic          unf_flag,
  input logic          push_evt,
  input logic          ovf_evt,
  input logic [1:0]    pop_cnt,
  input logic [PW-1:0] top_q
);

  logic is_read;
  assign is_read = cmd_valid && (cmd_code == 4'd4 || cmd_code == 4'd5);

  // R10
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_flag |=> ovf_flag);

  // R10
  ovf_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf_flag) |-> $past(ovf_evt));

  // R11
  unf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    unf_flag |=> unf_flag);

  // R3
  rd_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    is_read |=> rd_valid);

  // R3
  rd_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !is_read |=> !rd_valid);

  // R2
  push_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push_evt |=> top_q == PW'($past(top_q) - 1'b1));

  // R8
  pop_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_cnt == 2'd1) |=> top_q == PW'($past(top_q) + 1'b1));

  // R9
  pop_two_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_code == 4'd9) |=> top_q == PW'($past(top_q) + 2'd2));

  // R5
  free_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_code == 4'd7) |=> $stable(top_q));

  // R9
  op_go_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op_go |-> cmd_valid && (cmd_code == 4'd9 || cmd_code == 4'd10));

endmodule

bind rsf_stack_file rsf_stack_chk #(.PW(PW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
  .op_go(op_go), .rd_valid(rd_valid), .ovf_flag(ovf_flag), .unf_flag(unf_flag),
  .push_evt(push_evt), .ovf_evt(ovf_evt), .pop_cnt(pop_cnt), .top_q(top_q)
);

// File: tb/sim_rsf_stack_file.sv
module sim_rsf_stack_file;

  localparam int W = 16;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          cmd_valid;
  logic [3:0]    cmd_code;
  logic [2:0]    cmd_idx;
  logic          cmd_to_rel, cmd_pop, cmd_rev, cmd_ext;
  logic [W-1:0]  cmd_data;
  logic          op_go;
  logic [W-1:0]  op_a, op_b, op_result;
  logic          rd_valid;
  logic [W-1:0]  rd_data;
  logic          ovf_flag, unf_flag;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;   // 50 MHz

  // Order-sensitive stand-in for the arithmetic unit.
  assign op_result = op_a - op_b;

  rsf_stack_file #(.W(W), .DEPTH(8), .ONE_VALUE(16'h0001)) u0 (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
    .cmd_idx(cmd_idx), .cmd_to_rel(cmd_to_rel), .cmd_pop(cmd_pop),
    .cmd_rev(cmd_rev), .cmd_ext(cmd_ext), .cmd_data(cmd_data),
    .op_go(op_go), .op_a(op_a), .op_b(op_b), .op_result(op_result),
    .rd_valid(rd_valid), .rd_data(rd_data), .ovf_flag(ovf_flag), .unf_flag(unf_flag)
  );

  typedef struct packed {
    logic [3:0]   code;
    logic [2:0]   idx;
    logic [3:0]   fl;     // {to_rel, pop, rev, ext}
    logic [W-1:0] data;
    logic         erv;
    logic [W-1:0] erd;
    logic [1:0]   eflag;  // {ovf, unf}
    logic [3:0]   req;
  } vec_t;

  function automatic vec_t mk(logic [3:0] c, logic [2:0] i, logic [3:0] f,
                              logic [W-1:0] d, logic rv, logic [W-1:0] rd,
                              logic [1:0] ef, logic [3:0] rq);
    return '{code: c, idx: i, fl: f, data: d, erv: rv, erd: rd, eflag: ef, req: rq};
  endfunction

  localparam int NV = 20;
  localparam vec_t VEC [NV] = '{
    mk(4'd1,  3'd0, 4'b0000, 16'h0010, 1'b0, 16'h0000, 2'b00, 4'd2),  // R2 push
    mk(4'd1,  3'd0, 4'b0000, 16'h0030, 1'b0, 16'h0000, 2'b00, 4'd2),  // R2 push
    mk(4'd4,  3'd0, 4'b0000, 16'h0000, 1'b1, 16'h0030, 2'b00, 4'd3),  // R3 read
    mk(4'd10, 3'd1, 4'b0000, 16'h0000, 1'b0, 16'h0000, 2'b00, 4'd6),  // R6 ST0=30-10
    mk(4'd4,  3'd0, 4'b0000, 16'h0000, 1'b1, 16'h0020, 2'b00, 4'd6),  // R6
    mk(4'd10, 3'd1, 4'b0010, 16'h0000, 1'b0, 16'h0000, 2'b00, 4'd7),  // R7 ST0=10-20
    mk(4'd4,  3'd0, 4'b0000, 16'h0000, 1'b1, 16'hFFF0, 2'b00, 4'd7),  // R7
    mk(4'd10, 3'd0, 4'b0001, 16'h0005, 1'b0, 16'h0000, 2'b00, 4'd6),  // R6 ext operand
    mk(4'd6,  3'd1, 4'b0000, 16'h0000, 1'b0, 16'h0000, 2'b00, 4'd4),  // R4 exchange
    mk(4'd4,  3'd0, 4'b0000, 16'h0000, 1'b1, 16'h0010, 2'b00, 4'd4),  // R4
    mk(4'd3,  3'd0, 4'b0000, 16'h0000, 1'b0, 16'h0000, 2'b00, 4'd2),  // R2 push one
    mk(4'd2,  3'd0, 4'b0000, 16'h0000, 1'b0, 16'h0000, 2'b00, 4'd2),  // R2 push zero
    mk(4'd10, 3'd2, 4'b1100, 16'h0000, 1'b0, 16'h0000, 2'b00, 4'd8),  // R8 ST2=0-10, pop
    mk(4'd5,  3'd0, 4'b0000, 16'h0000, 1'b1, 16'h0001, 2'b00, 4'd8),  // R8
    mk(4'd5,  3'd0, 4'b0000, 16'h0000, 1'b1, 16'hFFF0, 2'b00, 4'd8),  // R8
    mk(4'd1,  3'd0, 4'b0000, 16'h0007, 1'b0, 16'h0000, 2'b00, 4'd2),  // R2
    mk(4'd7,  3'd1, 4'b0000, 16'h0000, 1'b0, 16'h0000, 2'b00, 4'd5),  // R5 free ST1
    mk(4'd4,  3'd0, 4'b0000, 16'h0000, 1'b1, 16'h0007, 2'b00, 4'd5),  // R5 top kept
    mk(4'd8,  3'd0, 4'b0000, 16'h0000, 1'b0, 16'h0000, 2'b00, 4'd3),  // R3 pop
    mk(4'd4,  3'd0, 4'b0000, 16'h0000, 1'b1, 16'h0000, 2'b01, 4'd5)   // R5 R11 freed reads zero
  };

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic issue(logic [3:0] c, logic [2:0] i, logic [3:0] f, logic [W-1:0] d);
    cmd_valid = 1'b1; cmd_code = c; cmd_idx = i;
    {cmd_to_rel, cmd_pop, cmd_rev, cmd_ext} = f; cmd_data = d;
    @(negedge clk);
    cmd_valid = 1'b0; cmd_code = 4'd0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    cmd_valid = 1'b0; cmd_code = '0; cmd_idx = '0;
    cmd_to_rel = 1'b0; cmd_pop = 1'b0; cmd_rev = 1'b0; cmd_ext = 1'b0; cmd_data = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 reset outputs", {29'd0, rd_valid, ovf_flag, unf_flag}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      vec_t v;
      string msg;
      v = VEC[i];
      issue(v.code, v.idx, v.fl, v.data);
      msg = $sformatf("row %0d R%0d", i, v.req);
      check(msg, {13'd0, rd_valid, rd_valid ? rd_data : 16'h0, ovf_flag, unf_flag},
                 {13'd0, v.erv, v.erd, v.eflag});
    end

    // R1 reset clears the sticky underflow left by the table
    do_reset();
    check("R1 flags after reset", {30'd0, ovf_flag, unf_flag}, 32'd0);

    // R9 double pop: operands and pointer motion
    issue(4'd1, 3'd0, 4'b0000, 16'h0011);
    issue(4'd1, 3'd0, 4'b0000, 16'h0022);
    issue(4'd1, 3'd0, 4'b0000, 16'h0033);
    cmd_valid = 1'b1; cmd_code = 4'd9; cmd_idx = 3'd0; cmd_rev = 1'b1;
    #1;
    check("R9 op port", {15'd0, op_go, op_a}, {15'd0, 1'b1, 16'h0033});
    check("R9 op_b", {16'd0, op_b}, {16'd0, 16'h0022});
    @(negedge clk);
    cmd_valid = 1'b0; cmd_code = 4'd0; cmd_rev = 1'b0;
    cmd_valid = 1'b1; cmd_code = 4'd4;
    #1;
    check("R9 op_go low on read", {31'd0, op_go}, 32'd0);
    @(negedge clk);
    cmd_valid = 1'b0; cmd_code = 4'd0;
    check("R9 top after double pop", {14'd0, rd_valid, rd_data, unf_flag},
                                      {14'd0, 1'b1, 16'h0011, 1'b0});
    issue(4'd9, 3'd0, 4'b0000, 16'h0000);
    check("R11 double pop with one entry", {31'd0, unf_flag}, 32'd1);

    // R10 overflow after eight pushes and wrap of the pointer
    do_reset();
    for (int k = 0; k < 8; k++) issue(4'd1, 3'd0, 4'b0000, 16'h0100 + 16'(k));
    check("R10 eight pushes no overflow", {31'd0, ovf_flag}, 32'd0);
    issue(4'd1, 3'd0, 4'b0000, 16'h01FF);
    check("R10 ninth push overflow", {31'd0, ovf_flag}, 32'd1);
    issue(4'd4, 3'd0, 4'b0000, 16'h0000);
    check("R10 overwritten top", {15'd0, rd_valid, rd_data}, {15'd0, 1'b1, 16'h01FF});
    issue(4'd0, 3'd0, 4'b0000, 16'h0000);
    check("R10 flag sticky", {30'd0, ovf_flag, rd_valid}, {30'd0, 1'b1, 1'b0});

    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule